// File: doc/BRIEF.md
# System clock mode controller

The block holds the clock mode of a small processor core in a register with four meaningful bits. These bits choose whether the internal clock comes from the fast main oscillator or from the slow sub oscillator, set the divide ratio of the main clock, and turn each oscillator on or off. Software changes the mode by writing the register. The block accepts only the single steps that are safe for the oscillators. Any other write is refused: the register keeps its old value and an error flag pulses for one cycle.

The block also sequences the low-power states. A wait request gates only the CPU clock enable, and the timer and display enable keeps running. A stop request halts every clock enable and turns both oscillators off. When a wake event ends stop, a down-counter runs on the internal clock enable and holds the core in reset-release hold until the oscillator has had time to settle. The counter's reload value depends on the clock source currently selected. On leaving either state the mode that was in force before is still in force.

The main oscillator runs at the rate of `clk`. The sub oscillator is represented by a one-cycle `sub_tick` strobe at its own rate.

Top module: `sysclk_mode_ctl`

## Requirements
- R1: After reset the readback is 0x40: main clock selected, divide by 8, main oscillator running, sub oscillator off. Readback bits 3:0 always read 0.
- R2: Bit 6 selects the main divide ratio (0 = /2, 1 = /8). A write that changes only bit 6 is accepted in every mode and shows in the readback on the next cycle.
- R3: A write that changes more than one of bits 7 (source select), 5 (main stop) and 4 (sub run) is refused.
- R4: A write that leaves bit 7 = 1 with bit 4 = 0 is refused. This covers selecting the sub clock before the sub oscillator runs, and stopping the sub oscillator while it is selected.
- R5: A write that sets bit 5 = 1 while bit 7 = 0 is refused. The main oscillator can only be stopped while the sub clock is selected.
- R6: A write that clears bit 7 while it is 1 is refused unless `main_rdy` is high in the write cycle.
- R7: A refused write leaves the register unchanged, and `wr_err` is high for exactly the cycle after the write.
- R8: The internal clock enable pulses on every 2nd `clk` at divide-by-2, on every 8th `clk` at divide-by-8, and on every 2nd `sub_tick` when bit 7 = 1.
- R9: A stop request drops both oscillator enables and all clock enables, and raises `wake_hold`. After `wake`, `wake_hold` stays high for exactly MAIN_DLY internal enables when bit 7 = 0, or SUB_DLY enables when bit 7 = 1. It then falls, and the mode is unchanged.
- R10: A wait request gates `cpu_ce` while `per_ce` keeps pulsing. A `wake` returns the block to run.
- R11: Writes made during wait, stop or the wake-up delay are ignored and do not raise `wr_err`.
- R12: Outside stop, `main_osc_en` equals the inverse of bit 5, and `sub_osc_en` equals bit 4.
- R13: A write and a stop request in the same cycle: the write is judged and applied first, and the wake-up delay after that stop follows the newly written source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data, bits 7:4 used |
| stop_req | input | 1 | Request to enter stop |
| wait_req | input | 1 | Request to enter wait |
| wake | input | 1 | Wake event ending stop or wait |
| main_rdy | input | 1 | Main oscillator settled |
| sub_tick | input | 1 | One-cycle strobe at sub oscillator rate |
| mode_q | output | 8 | Register readback |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| src_sub | output | 1 | Source select to enable generator (1 = sub) |
| div_sel | output | 1 | Divider select (1 = /8) |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Timer and display clock enable |
| wake_hold | output | 1 | Held high during stop and wake-up delay |
| wr_err | output | 1 | One-cycle pulse on a refused write |

## Verification
A register write and a stop request can arrive in the same cycle. The bench provokes this by switching to the sub clock in exactly the cycle where stop is requested. It then judges the outcome by the new readback, and by counting `per_ce` pulses while `wake_hold` is high: the count must equal the sub-clock delay, not the main-clock one. Every write's expected readback and error flag are queued by the driver and popped by a monitor one cycle later. Writes issued inside stop and wait are checked the same way and must leave the mode untouched.

// File: rtl/sysclk_mode_ctl.sv
module sysclk_mode_ctl #(
  parameter int MAIN_DLY = 2000,
  parameter int SUB_DLY  = 4000,
  localparam int DMAX = (MAIN_DLY > SUB_DLY) ? MAIN_DLY : SUB_DLY,
  localparam int CW   = $clog2(DMAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       wake,
  input  logic       main_rdy,
  input  logic       sub_tick,
  output logic [7:0] mode_q,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic       src_sub,
  output logic       div_sel,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic       wake_hold,
  output logic       wr_err
);
  typedef enum logic [1:0] {S_RUN, S_WAIT, S_STOP, S_WARM} pst_t;

  pst_t          st;
  logic [3:0]    mode;
  logic [CW-1:0] dly;
  logic [2:0]    pre;
  logic          half;
  logic          sys_ce;

  wire [3:0] nxt   = wr_data[7:4];
  wire [3:0] chg   = (nxt ^ mode) & 4'b1011;
  wire       multi = (chg[3] & chg[1]) | (chg[3] & chg[0]) | (chg[1] & chg[0]);
  wire       bad   = multi
                   | (nxt[3] & ~nxt[0])
                   | (nxt[1] & ~nxt[3])
                   | (mode[3] & ~nxt[3] & ~main_rdy);
  wire       take  = wr_en && st == S_RUN;

  always_comb begin
    if (st == S_STOP)  sys_ce = 1'b0;
    else if (mode[3])  sys_ce = sub_tick & half;
    else if (mode[2])  sys_ce = &pre;
    else               sys_ce = pre[0];
  end

  assign mode_q      = {mode, 4'b0000};
  assign src_sub     = mode[3];
  assign div_sel     = mode[2];
  assign main_osc_en = ~mode[1] && st != S_STOP;
  assign sub_osc_en  = mode[0] && st != S_STOP;
  assign cpu_ce      = sys_ce && st == S_RUN;
  assign per_ce      = sys_ce;
  assign wake_hold   = st == S_STOP || st == S_WARM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      half <= 1'b0;
    end else begin
      pre <= pre + 3'd1;
      if (sub_tick) half <= ~half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= 4'b0100;
      wr_err <= 1'b0;
    end else begin
      wr_err <= take && bad;
      if (take && !bad) mode <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      dly <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (stop_req)      st <= S_STOP;
          else if (wait_req) st <= S_WAIT;
        end
        S_WAIT: if (wake) st <= S_RUN;
        S_STOP: if (wake) begin
          st  <= S_WARM;
          dly <= mode[3] ? CW'(SUB_DLY) : CW'(MAIN_DLY);
        end
        S_WARM: if (sys_ce) begin
          dly <= dly - 1'b1;
          if (dly == CW'(1)) st <= S_RUN;
        end
        default: st <= S_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sysclk_mode_ctl_chk.sv
module sysclk_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       main_rdy,
  input logic [7:0] mode_q,
  input logic       main_osc_en,
  input logic       sub_osc_en,
  input logic       cpu_ce,
  input logic       wake_hold,
  input logic       wr_err
);
  p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[3:0] == 4'h0);
  p_single_osc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $countones(($past(mode_q) ^ mode_q) & 8'hB0) <= 1);
  p_sub_runs_when_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7] |-> mode_q[4]);
  p_main_stop_only_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[5] |-> mode_q[7]);
  p_main_ready_on_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q[7]) |-> $past(main_rdy));
  p_err_keeps_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $stable(mode_q) && $past(wr_en));
  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hold |-> !cpu_ce);
  p_osc_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_hold |-> main_osc_en == !mode_q[5] && sub_osc_en == mode_q[4]);
endmodule

bind sysclk_mode_ctl sysclk_mode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .main_rdy(main_rdy),
  .mode_q(mode_q), .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
  .cpu_ce(cpu_ce), .wake_hold(wake_hold), .wr_err(wr_err)
);

// File: tb/test_sysclk_mode_ctl.sv
module test_sysclk_mode_ctl;
  localparam int MD = 12;
  localparam int SD = 20;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, stop_req = 0, wait_req = 0, wake = 0, main_rdy = 1;
  logic [7:0] wr_data = '0;
  logic [1:0] tcnt = '0;
  logic sub_tick;
  logic [7:0] mode_q;
  logic main_osc_en, sub_osc_en, src_sub, div_sel, cpu_ce, per_ce, wake_hold, wr_err;

  int checks = 0, errors = 0;
  logic [7:0] mdl = 8'h40;
  logic in_run = 1;

  typedef struct { logic [7:0] m; logic e; string tag; } exp_t;
  exp_t q[$];
  event ev;

  always #5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign sub_tick = (tcnt == 2'd3);

  sysclk_mode_ctl #(.MAIN_DLY(MD), .SUB_DLY(SD)) i_sysclk_mode_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stop_req(stop_req), .wait_req(wait_req), .wake(wake), .main_rdy(main_rdy),
    .sub_tick(sub_tick), .mode_q(mode_q), .main_osc_en(main_osc_en),
    .sub_osc_en(sub_osc_en), .src_sub(src_sub), .div_sel(div_sel),
    .cpu_ce(cpu_ce), .per_ce(per_ce), .wake_hold(wake_hold), .wr_err(wr_err));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic refused(input logic [7:0] o, input logic [7:0] n, input logic rdy);
    int c = int'(o[7] != n[7]) + int'(o[5] != n[5]) + int'(o[4] != n[4]);
    return (c > 1) || (n[7] && !n[4]) || (n[5] && !n[7]) || (o[7] && !n[7] && !rdy);
  endfunction

  task automatic do_write(input logic [7:0] d, input logic with_stop, input string tag);
    exp_t x;
    logic r;
    @(negedge clk);
    wr_en = 1; wr_data = d; stop_req = with_stop;
    r = in_run && refused(mdl, d, main_rdy);
    if (in_run && !r) mdl = {d[7:4], 4'h0};
    x.m = mdl; x.e = r; x.tag = tag;
    @(negedge clk);
    wr_en = 0; stop_req = 0;
    q.push_back(x);
    -> ev;
  endtask

  initial forever begin
    exp_t x;
    @(ev);
    while (q.size() > 0) begin
      x = q.pop_front();
      chk(mode_q == x.m, {x.tag, " mode"}, mode_q, x.m);
      chk(wr_err == x.e, {x.tag, " err"}, wr_err, x.e);
    end
  end

  task automatic count_ce(input int n, output int c, output int p);
    c = 0; p = 0;
    repeat (n) begin
      @(negedge clk);
      if (cpu_ce) c++;
      if (per_ce) p++;
    end
  endtask

  task automatic wake_count(output int p);
    int guard = 0;
    p = 0;
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0;
    while (wake_hold && guard < 5000) begin
      if (per_ce) p++;
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    int c, p;
    #10000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mode_q == 8'h40, "R1 reset value", mode_q, 8'h40);
    chk(main_osc_en && !sub_osc_en, "R12 reset osc enables", {main_osc_en, sub_osc_en}, 2'b10);
    chk(!wake_hold && !wr_err, "R1 reset flags", {wake_hold, wr_err}, 0);

    count_ce(64, c, p);
    chk(c == 8, "R8 middle rate", c, 8);
    do_write(8'h00, 0, "R2 to high speed");
    count_ce(64, c, p);
    chk(c == 32, "R8 high rate", c, 32);

    do_write(8'h80, 0, "R4 low without sub");
    do_write(8'h90, 0, "R3 two osc bits");
    do_write(8'h10, 0, "R12 start sub");
    chk(sub_osc_en && main_osc_en, "R12 both osc on", {main_osc_en, sub_osc_en}, 2'b11);
    do_write(8'h30, 0, "R5 stop main on main clock");
    do_write(8'h90, 0, "R4 select sub");
    count_ce(64, c, p);
    chk(c == 8, "R8 low rate", c, 8);
    do_write(8'h80, 0, "R4 kill selected sub");
    do_write(8'hB0, 0, "R12 stop main");
    chk(!main_osc_en && sub_osc_en, "R12 main off", {main_osc_en, sub_osc_en}, 2'b01);
    do_write(8'hF0, 0, "R2 divider in low mode");
    do_write(8'hB0, 0, "R2 divider back");

    pulse(stop_req);
    in_run = 0;
    chk(!main_osc_en && !sub_osc_en && wake_hold, "R9 stop state",
        {main_osc_en, sub_osc_en, wake_hold}, 3'b001);
    count_ce(40, c, p);
    chk(c == 0 && p == 0, "R9 no enables in stop", c + p, 0);
    do_write(8'hF0, 0, "R11 write in stop");
    wake_count(p);
    in_run = 1;
    chk(p == SD, "R9 sub delay", p, SD);
    chk(mode_q == 8'hB0, "R9 mode kept", mode_q, 8'hB0);

    do_write(8'h90, 0, "R12 restart main");
    main_rdy = 0;
    do_write(8'h10, 0, "R6 main not ready");
    main_rdy = 1;
    do_write(8'h10, 0, "R6 main ready");

    do_write(8'h90, 1, "R13 write with stop");
    in_run = 0;
    chk(wake_hold, "R13 stop entered", wake_hold, 1);
    wake_count(p);
    in_run = 1;
    chk(p == SD, "R13 delay from new source", p, SD);
    do_write(8'h10, 0, "R6 return to main");

    pulse(stop_req);
    in_run = 0;
    wake_count(p);
    in_run = 1;
    chk(p == MD, "R9 main delay", p, MD);

    pulse(wait_req);
    in_run = 0;
    count_ce(64, c, p);
    chk(c == 0, "R10 cpu gated", c, 0);
    chk(p == 32, "R10 timer runs", p, 32);
    do_write(8'h50, 0, "R11 write in wait");
    pulse(wake);
    in_run = 1;
    count_ce(64, c, p);
    chk(c == 32, "R10 cpu resumes", c, 32);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule